// File: doc/BRIEF.md
# SATA Host Controller Register File

This block is the software-visible register space of a multi-port SATA host controller. A single 32-bit slave port (write strobe, read strobe, word address and data) reaches a handful of global registers and one 128-byte register window per port. Each register applies its own write rule: some bits clear when written with one, some accumulate ones, some fields are masked or read-only, and some registers are computed at read time from the current state of the link. Read data appears on the bus one clock after the read strobe.

The per-port interrupt status, gated by the per-port mask, is folded into a global status word with one bit per port. A single level interrupt output follows that word and the global interrupt-enable bit. Software can also reach every register through an index/data pair. The block gives the rest of the controller a controller-wide reset pulse, a per-port reset pulse, and start/stop requests for each port's command-list engine and receive engine. Engines, the link and device-side events enter as plain input vectors.

Top module: `sata_host_regs`

## Requirements
- R1: After the reset input (active low) the control register reads 0x80000000, the global interrupt status reads 0, every port's command, status, mask, error, active and issue registers read 0, the task-file register reads 0x0000007F, the signature register reads 0xFFFFFFFF and `irq_o` is low.
- R2: A read strobe returns the addressed register on `bus_rdata` in the following cycle. The value is held until the next read.
- R3: Global registers sit at 0x00 (capabilities = (ports-1) | 31<<8 | 1<<20), 0x04 (control), 0x08 (global interrupt status), 0x0C (implemented ports, one bit per port) and 0x10 (version). Port p's window starts at 0x100 + 128*p, and the offset within the window selects the register. Addresses past the last port and unmapped offsets read 0, and writes to them change nothing.
- R4: A write whose address has either of bits [1:0] set is dropped.
- R5: Port interrupt status (window offset 0x04) is set by the bits of `irq_event` and cleared by writing ones. When an event and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R6: Port interrupt mask (offset 0x08) stores the written value ANDed with 0xFDC000FF.
- R7: Bit p of the global interrupt status is 1 exactly when port p's status ANDed with its mask is non-zero. `irq_o` is high exactly when that word is non-zero and control bit 1 (interrupt enable) is set.
- R8: A control write with bit 0 set pulses `hba_reset_o` for one cycle. In the cycle after the write, every register returns to its R1 value. Any other control write stores bit 1 and forces bit 31 to one, and all other bits read 0.
- R9: In the port command register (offset 0x00), bit 15 reads `list_running`, bit 14 reads `rx_running`, bits [13:8] read 0, bits [31:28] are forced to 0, and all other bits keep the written value.
- R10: A command write pulses, one cycle later and for one cycle: `list_start_o` if bit 0 is written 1 while the list engine is stopped, `list_stop_o` if bit 0 is written 0 while it runs, and `rx_start_o` / `rx_stop_o` in the same way for bit 4 and the receive engine.
- R11: The error register (offset 0x14) is set by `err_event` and cleared by writing ones. The active register (0x18) and issue register (0x1C) gain the ones written to them, and writes never clear them; only `slot_retire` clears their bits.
- R12: A write to the control field at offset 0x0C that takes bits [3:0] from 1 to 0 pulses `port_reset_o` for one cycle, starting the cycle after the write, and clears that port's error and active registers. A write that takes [3:0] from any other value to 0 raises no pulse. The task-file register (0x20) reads 0x7F and the signature register (0x24) reads 0xFFFFFFFF.
- R13: The link status register (offset 0x10) reads 0x00000113 when `dev_present` is high for that port, and 0 otherwise.
- R14: The index register (0x20) stores the written value with bits [1:0] cleared and with only address-width bits kept. Reads and writes of the data register (0x24) act on the register at the address the index holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| dev_present | input | NPORTS | Device attached and link up, per port |
| irq_event | input | NPORTS*32 | Interrupt-status set bits, 32 per port |
| err_event | input | NPORTS*32 | Error-register set bits, 32 per port |
| slot_retire | input | NPORTS*32 | Clears active and issue bits, 32 per port |
| list_running | input | NPORTS | Command-list engine running, per port |
| rx_running | input | NPORTS | Receive engine running, per port |
| irq_o | output | 1 | Level interrupt |
| hba_reset_o | output | 1 | Controller reset pulse |
| port_reset_o | output | NPORTS | Port reset pulse |
| list_start_o | output | NPORTS | List engine start request |
| list_stop_o | output | NPORTS | List engine stop request |
| rx_start_o | output | NPORTS | Receive engine start request |
| rx_stop_o | output | NPORTS | Receive engine stop request |

## Verification
A wrong port-select decode writes the pattern meant for one port into a neighbour. That shows up on the very next read of either window, which is why every port is written with a distinct mask pattern and all of them are read back. A stale status or mask bit reaches `irq_o` and the global status in the same cycle as the bad update, with no pipeline to hide it, so the interrupt sweep compares both against every combination of pending ports. Request and reset pulses are sampled in the cycle after the write and once more a cycle later, so a pulse that is late, missing or stretched is reported directly.

// File: rtl/sata_hp_pkg.sv
// Shared constants and types of the SATA host register file.
// Assumes a 32-bit data path and 128-byte port windows.
package sata_hp_pkg;

    localparam int DW        = 32;
    localparam int POFF_W    = 7;
    localparam int PORT_BASE = 'h100;

    // global register offsets
    localparam int G_CAP  = 'h00;
    localparam int G_CTL  = 'h04;
    localparam int G_ISR  = 'h08;
    localparam int G_IMPL = 'h0C;
    localparam int G_VER  = 'h10;
    localparam int G_IDX  = 'h20;
    localparam int G_DATA = 'h24;

    // offsets inside a port window
    localparam logic [POFF_W-1:0] P_CMD   = 7'h00;
    localparam logic [POFF_W-1:0] P_ISR   = 7'h04;
    localparam logic [POFF_W-1:0] P_IMSK  = 7'h08;
    localparam logic [POFF_W-1:0] P_SCTL  = 7'h0C;
    localparam logic [POFF_W-1:0] P_SSTS  = 7'h10;
    localparam logic [POFF_W-1:0] P_SERR  = 7'h14;
    localparam logic [POFF_W-1:0] P_SACT  = 7'h18;
    localparam logic [POFF_W-1:0] P_ISSUE = 7'h1C;
    localparam logic [POFF_W-1:0] P_TFD   = 7'h20;
    localparam logic [POFF_W-1:0] P_SIG   = 7'h24;
    localparam logic [POFF_W-1:0] P_LBL   = 7'h28;
    localparam logic [POFF_W-1:0] P_LBH   = 7'h2C;
    localparam logic [POFF_W-1:0] P_RBL   = 7'h30;
    localparam logic [POFF_W-1:0] P_RBH   = 7'h34;

    localparam logic [DW-1:0] IMSK_KEEP = 32'hFDC0_00FF;
    localparam logic [DW-1:0] CMD_RO    = 32'h0000_FF00;
    localparam logic [DW-1:0] CMD_PWR   = 32'hF000_0000;
    localparam int CMD_LIST_EN  = 0;
    localparam int CMD_RX_EN    = 4;
    localparam int CMD_RX_RUN   = 14;
    localparam int CMD_LIST_RUN = 15;

    localparam logic [DW-1:0] TFD_IDLE  = 32'h0000_007F;
    localparam logic [DW-1:0] SIG_IDLE  = 32'hFFFF_FFFF;
    localparam logic [DW-1:0] SSTS_UP   = 32'h0000_0113;
    localparam logic [DW-1:0] CTL_INIT  = 32'h8000_0000;
    localparam logic [DW-1:0] VERSION   = 32'h0001_0300;

    typedef struct packed {
        logic list_start;
        logic list_stop;
        logic rx_start;
        logic rx_stop;
    } eng_req_t;

endpackage

// File: rtl/sata_hp_port.sv
// One port's register window: stores the port registers, applies each
// register's write rule, and produces read data, pending-interrupt state,
// the port reset pulse and the engine requests.
// Assumes wr_en is already qualified by port select and word alignment.
module sata_hp_port
    import sata_hp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [POFF_W-1:0] off,
    input  logic [DW-1:0]     wdata,
    input  logic [DW-1:0]     evt_irq,
    input  logic [DW-1:0]     evt_err,
    input  logic [DW-1:0]     retire,
    input  logic              list_run,
    input  logic              rx_run,
    input  logic              dev_present,
    output logic [DW-1:0]     rd_val,
    output logic              pend,
    output logic              port_rst,
    output eng_req_t          eng_req
);

    logic [DW-1:0] cmd_q, isr_q, imsk_q, sctl_q, serr_q, sact_q, issue_q;
    logic [DW-1:0] lbl_q, lbh_q, rbl_q, rbh_q;
    logic w_cmd, w_isr, w_imsk, w_sctl, w_serr, w_sact, w_issue;
    logic w_lbl, w_lbh, w_rbl, w_rbh, det_fall, hold_rst;

    assign hold_rst = !rst_n || clr;

    // write strobes per register
    always_comb begin
        w_cmd   = wr_en && off == P_CMD;
        w_isr   = wr_en && off == P_ISR;
        w_imsk  = wr_en && off == P_IMSK;
        w_sctl  = wr_en && off == P_SCTL;
        w_serr  = wr_en && off == P_SERR;
        w_sact  = wr_en && off == P_SACT;
        w_issue = wr_en && off == P_ISSUE;
        w_lbl   = wr_en && off == P_LBL;
        w_lbh   = wr_en && off == P_LBH;
        w_rbl   = wr_en && off == P_RBL;
        w_rbh   = wr_en && off == P_RBH;
        det_fall = w_sctl && sctl_q[3:0] == 4'd1 && wdata[3:0] == 4'd0;
    end

    // plain storage registers: command, mask, control, buffer bases
    always_ff @(posedge clk) begin
        if (hold_rst) begin
            cmd_q  <= '0;
            imsk_q <= '0;
            sctl_q <= '0;
            lbl_q  <= '0;
            lbh_q  <= '0;
            rbl_q  <= '0;
            rbh_q  <= '0;
        end else begin
            if (w_cmd)  cmd_q  <= wdata & ~(CMD_RO | CMD_PWR);
            if (w_imsk) imsk_q <= wdata & IMSK_KEEP;
            if (w_sctl) sctl_q <= wdata;
            if (w_lbl)  lbl_q  <= wdata;
            if (w_lbh)  lbh_q  <= wdata;
            if (w_rbl)  rbl_q  <= wdata;
            if (w_rbh)  rbh_q  <= wdata;
        end
    end

    // interrupt status: hardware sets, software clears with ones, set wins
    always_ff @(posedge clk) begin
        if (hold_rst) isr_q <= '0;
        else          isr_q <= (isr_q & ~(w_isr ? wdata : '0)) | evt_irq;
    end

    // error register: hardware sets, software clears, port reset empties it
    always_ff @(posedge clk) begin
        if (hold_rst)      serr_q <= '0;
        else if (det_fall) serr_q <= evt_err;
        else               serr_q <= (serr_q & ~(w_serr ? wdata : '0)) | evt_err;
    end

    // active and issue: software sets, only slot retirement clears
    always_ff @(posedge clk) begin
        if (hold_rst) begin
            sact_q  <= '0;
            issue_q <= '0;
        end else begin
            sact_q  <= det_fall ? '0 : (sact_q | (w_sact ? wdata : '0)) & ~retire;
            issue_q <= (issue_q | (w_issue ? wdata : '0)) & ~retire;
        end
    end

    // single-cycle port reset and engine request pulses
    always_ff @(posedge clk) begin
        if (hold_rst) begin
            port_rst <= 1'b0;
            eng_req  <= '0;
        end else begin
            port_rst           <= det_fall;
            eng_req.list_start <= w_cmd &&  wdata[CMD_LIST_EN] && !list_run;
            eng_req.list_stop  <= w_cmd && !wdata[CMD_LIST_EN] &&  list_run;
            eng_req.rx_start   <= w_cmd &&  wdata[CMD_RX_EN]   && !rx_run;
            eng_req.rx_stop    <= w_cmd && !wdata[CMD_RX_EN]   &&  rx_run;
        end
    end

    // read data and pending state
    always_comb begin
        pend = |(isr_q & imsk_q);
        case (off)
            P_CMD: begin
                rd_val = cmd_q;
                rd_val[CMD_LIST_RUN] = list_run;
                rd_val[CMD_RX_RUN]   = rx_run;
            end
            P_ISR:   rd_val = isr_q;
            P_IMSK:  rd_val = imsk_q;
            P_SCTL:  rd_val = sctl_q;
            P_SSTS:  rd_val = dev_present ? SSTS_UP : '0;
            P_SERR:  rd_val = serr_q;
            P_SACT:  rd_val = sact_q;
            P_ISSUE: rd_val = issue_q;
            P_TFD:   rd_val = TFD_IDLE;
            P_SIG:   rd_val = SIG_IDLE;
            P_LBL:   rd_val = lbl_q;
            P_LBH:   rd_val = lbh_q;
            P_RBL:   rd_val = rbl_q;
            P_RBH:   rd_val = rbh_q;
            default: rd_val = '0;
        endcase
    end

    // R5: a clearing write leaves no written one set unless an event re-set it
    assert_isr_w1c_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(w_isr) |-> ((isr_q & $past(wdata) & ~$past(evt_irq)) == '0));

    // R11: issue bits only drop when retired or on controller reset
    assert_issue_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clr) |-> (($past(issue_q) & ~$past(retire) & ~issue_q) == '0));

    // R12: port reset is a single-cycle pulse
    assert_port_rst_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        port_rst |=> !port_rst);

    // R10: never start and stop the same engine at once
    assert_eng_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({eng_req.list_start, eng_req.list_stop}) &&
        $onehot0({eng_req.rx_start, eng_req.rx_stop}));

endmodule

// File: rtl/sata_hp_irq.sv
// Folds per-port pending flags into the global status word and the level
// interrupt. Assumes NPORTS does not exceed the data width.
module sata_hp_irq
    import sata_hp_pkg::*;
#(
    parameter int NPORTS = 4
)(
    input  logic [NPORTS-1:0] pend,
    input  logic              ien,
    output logic [DW-1:0]     gstat,
    output logic              irq
);

    // aggregate status and gated interrupt line
    always_comb begin
        gstat = DW'(pend);
        irq   = (|pend) && ien;
    end

endmodule

// File: rtl/sata_host_regs.sv
// Top of the SATA host register file: word decode, global registers,
// index/data indirection, per-port windows and registered read data.
// Assumes PORT_BASE is a multiple of 128 and that the window
// PORT_BASE + 128*NPORTS fits inside 2**ADDR_W bytes.
module sata_host_regs
    import sata_hp_pkg::*;
#(
    parameter int NPORTS = 4,
    parameter int ADDR_W = 10
)(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DW-1:0]        bus_wdata,
    output logic [DW-1:0]        bus_rdata,
    input  logic [NPORTS-1:0]    dev_present,
    input  logic [NPORTS*DW-1:0] irq_event,
    input  logic [NPORTS*DW-1:0] err_event,
    input  logic [NPORTS*DW-1:0] slot_retire,
    input  logic [NPORTS-1:0]    list_running,
    input  logic [NPORTS-1:0]    rx_running,
    output logic                 irq_o,
    output logic                 hba_reset_o,
    output logic [NPORTS-1:0]    port_reset_o,
    output logic [NPORTS-1:0]    list_start_o,
    output logic [NPORTS-1:0]    list_stop_o,
    output logic [NPORTS-1:0]    rx_start_o,
    output logic [NPORTS-1:0]    rx_stop_o
);

    localparam int BLK_W    = ADDR_W - POFF_W;
    localparam int BASE_BLK = PORT_BASE / 128;
    localparam logic [DW-1:0] CAP_VAL =
        DW'(NPORTS - 1) | (DW'(31) << 8) | (DW'(1) << 20);
    localparam logic [DW-1:0] IMPL_VAL = DW'((64'd1 << NPORTS) - 64'd1);

    logic [ADDR_W-1:0] word_addr, tgt, idx_q;
    logic              is_idx, is_data, wr_ok, in_port, hba_rst_q;
    logic [DW-1:0]     ctl_q, gstat, rd_val;
    logic [NPORTS-1:0] port_sel, pend;
    logic [DW-1:0]     prd [NPORTS];
    eng_req_t          eng [NPORTS];

    // address decode: direct or forwarded through the index register
    always_comb begin
        word_addr = {bus_addr[ADDR_W-1:2], 2'b00};
        is_idx    = word_addr == ADDR_W'(G_IDX);
        is_data   = word_addr == ADDR_W'(G_DATA);
        tgt       = is_data ? idx_q : word_addr;
        wr_ok     = bus_wr && bus_addr[1:0] == 2'b00;
        in_port   = |port_sel;
    end

    // controller reset pulse, one cycle, never back to back
    always_ff @(posedge clk) begin
        if (!rst_n) hba_rst_q <= 1'b0;
        else        hba_rst_q <= wr_ok && !in_port && tgt == ADDR_W'(G_CTL)
                                 && bus_wdata[0] && !hba_rst_q;
    end

    // global control register: interrupt enable, mode bit forced on
    always_ff @(posedge clk) begin
        if (!rst_n || hba_rst_q)
            ctl_q <= CTL_INIT;
        else if (wr_ok && !in_port && tgt == ADDR_W'(G_CTL) && !bus_wdata[0])
            ctl_q <= CTL_INIT | {30'd0, bus_wdata[1], 1'b0};
    end

    // index register, written only by direct access
    always_ff @(posedge clk) begin
        if (!rst_n || hba_rst_q) idx_q <= '0;
        else if (wr_ok && is_idx) idx_q <= {bus_wdata[ADDR_W-1:2], 2'b00};
    end

    // port windows
    for (genvar i = 0; i < NPORTS; i++) begin : g_port
        assign port_sel[i] = tgt[ADDR_W-1:POFF_W] == BLK_W'(BASE_BLK + i);

        sata_hp_port u_port (
            .clk         (clk),
            .rst_n       (rst_n),
            .clr         (hba_rst_q),
            .wr_en       (wr_ok && port_sel[i]),
            .off         (tgt[POFF_W-1:0]),
            .wdata       (bus_wdata),
            .evt_irq     (irq_event[i*DW +: DW]),
            .evt_err     (err_event[i*DW +: DW]),
            .retire      (slot_retire[i*DW +: DW]),
            .list_run    (list_running[i]),
            .rx_run      (rx_running[i]),
            .dev_present (dev_present[i]),
            .rd_val      (prd[i]),
            .pend        (pend[i]),
            .port_rst    (port_reset_o[i]),
            .eng_req     (eng[i])
        );

        assign list_start_o[i] = eng[i].list_start;
        assign list_stop_o[i]  = eng[i].list_stop;
        assign rx_start_o[i]   = eng[i].rx_start;
        assign rx_stop_o[i]    = eng[i].rx_stop;
    end

    sata_hp_irq #(.NPORTS(NPORTS)) u_irq (
        .pend  (pend),
        .ien   (ctl_q[1]),
        .gstat (gstat),
        .irq   (irq_o)
    );

    // read mux over index, port windows and global registers
    always_comb begin
        rd_val = '0;
        if (!is_data && is_idx) begin
            rd_val = DW'(idx_q);
        end else if (in_port) begin
            for (int i = 0; i < NPORTS; i++)
                if (port_sel[i]) rd_val = prd[i];
        end else begin
            case (tgt)
                ADDR_W'(G_CAP):  rd_val = CAP_VAL;
                ADDR_W'(G_CTL):  rd_val = ctl_q;
                ADDR_W'(G_ISR):  rd_val = gstat;
                ADDR_W'(G_IMPL): rd_val = IMPL_VAL;
                ADDR_W'(G_VER):  rd_val = VERSION;
                default:         rd_val = '0;
            endcase
        end
    end

    // registered read data, one cycle after the strobe
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_val;
    end

    assign hba_reset_o = hba_rst_q;

    // R7: interrupt only with enable set and some port pending
    assert_irq_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (ctl_q[1] && (|pend)));

    // R8: controller reset is a single-cycle pulse
    assert_hba_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hba_rst_q |=> !hba_rst_q);

    // R8: the mode bit of the control register never reads zero
    assert_ctl_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q[31] && ctl_q[0] == 1'b0);

    // R14: forwarded addresses are always word aligned
    assert_index_aligned_R14: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q[1:0] == 2'b00);

endmodule

// File: tb/sata_host_regs_tb.sv
`timescale 1ns/1ps
module sata_host_regs_tb;
    localparam int NP = 4;
    localparam int AW = 10;
    localparam int W  = 32;

    localparam logic [AW-1:0] A_CAP = 10'h00, A_CTL = 10'h04, A_GISR = 10'h08,
                              A_IMPL = 10'h0C, A_IDX = 10'h20, A_DATA = 10'h24;
    localparam int O_CMD = 'h00, O_ISR = 'h04, O_IMSK = 'h08, O_SCTL = 'h0C,
                   O_SSTS = 'h10, O_SERR = 'h14, O_SACT = 'h18, O_ISSUE = 'h1C,
                   O_TFD = 'h20, O_SIG = 'h24;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, bus_wr, bus_rd, irq_o, hba_reset_o;
    logic [AW-1:0] bus_addr;
    logic [W-1:0]  bus_wdata, bus_rdata;
    logic [NP-1:0] dev_present, list_running, rx_running;
    logic [NP-1:0] port_reset_o, list_start_o, list_stop_o, rx_start_o, rx_stop_o;
    logic [NP*W-1:0] irq_event, err_event, slot_retire;

    sata_host_regs #(.NPORTS(NP), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dev_present(dev_present), .irq_event(irq_event), .err_event(err_event),
        .slot_retire(slot_retire), .list_running(list_running),
        .rx_running(rx_running), .irq_o(irq_o), .hba_reset_o(hba_reset_o),
        .port_reset_o(port_reset_o), .list_start_o(list_start_o),
        .list_stop_o(list_stop_o), .rx_start_o(rx_start_o), .rx_stop_o(rx_stop_o)
    );

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;
    logic [W-1:0] v;

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] pa(input int p, input int off);
        return AW'(32'h100 + p * 128 + off);
    endfunction

    task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [W-1:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pulse_irq(input int p, input logic [W-1:0] bits);
        @(negedge clk);
        irq_event[p*W +: W] = bits;
        @(negedge clk);
        irq_event = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
        dev_present = '0; list_running = '0; rx_running = '0;
        irq_event = '0; err_event = '0; slot_retire = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state (R2 read path)
        check("R1 rdata idle", bus_rdata, 0);
        check("R1 irq low", W'(irq_o), 0);
        rd(A_CTL, v);  check("R1 ctl", v, 32'h8000_0000);
        rd(A_GISR, v); check("R1 gisr", v, 0);
        for (int p = 0; p < NP; p++) begin
            rd(pa(p, O_CMD), v);  check("R1 cmd", v, 0);
            rd(pa(p, O_IMSK), v); check("R1 imask", v, 0);
            rd(pa(p, O_ISSUE), v); check("R1 issue", v, 0);
            rd(pa(p, O_TFD), v);  check("R1 tfd", v, 32'h7F);
            rd(pa(p, O_SIG), v);  check("R1 sig", v, 32'hFFFF_FFFF);
        end

        // R3 global constants and port decode, R6 mask, R2 read latency
        rd(A_CAP, v);  check("R3 cap", v, 32'h0010_1F03);
        rd(A_IMPL, v); check("R3 impl", v, 32'hF);
        for (int p = 0; p < NP; p++) wr(pa(p, O_IMSK), 32'hFFFF_FFFF ^ (32'h11 << p));
        for (int p = 0; p < NP; p++) begin
            rd(pa(p, O_IMSK), v);
            check("R6 R3 imask per port", v, (32'hFFFF_FFFF ^ (32'h11 << p)) & 32'hFDC0_00FF);
        end
        wr(pa(NP, O_IMSK), 32'hFFFF_FFFF);
        rd(pa(NP, O_IMSK), v); check("R3 past last port", v, 0);
        rd(pa(0, 'h40), v);    check("R3 unmapped offset", v, 0);
        rd(pa(0, O_IMSK), v);  check("R3 port0 untouched", v, 32'hFDC0_00EE);

        // R4 misaligned write dropped
        wr(pa(0, O_IMSK) + 1, 32'h0);
        rd(pa(0, O_IMSK), v); check("R4 misaligned", v, 32'hFDC0_00EE);
        wr(A_CTL + 2, 32'h2);
        rd(A_CTL, v); check("R4 misaligned ctl", v, 32'h8000_0000);

        // R5 interrupt status set / clear / collision
        pulse_irq(1, 32'h0000_00F0);
        rd(pa(1, O_ISR), v); check("R5 event set", v, 32'hF0);
        wr(pa(1, O_ISR), 32'h30);
        rd(pa(1, O_ISR), v); check("R5 w1c", v, 32'hC0);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = pa(1, O_ISR); bus_wdata = 32'hFF;
        irq_event[1*W +: W] = 32'h80;
        @(negedge clk);
        bus_wr = 1'b0; irq_event = '0;
        rd(pa(1, O_ISR), v); check("R5 set wins", v, 32'h80);

        // R7 aggregate status and interrupt over all port combinations
        for (int p = 0; p < NP; p++) begin
            wr(pa(p, O_IMSK), 32'h1);
            wr(pa(p, O_ISR), 32'hFFFF_FFFF);
        end
        for (int en = 0; en < 2; en++) begin
            wr(A_CTL, en ? 32'h2 : 32'h0);
            for (int m = 0; m < 16; m++) begin
                for (int p = 0; p < NP; p++) begin
                    wr(pa(p, O_ISR), 32'hFFFF_FFFF);
                    if (m[p]) pulse_irq(p, 32'h1);
                end
                pulse_irq(0, 32'h2);   // masked bit never counts
                rd(A_GISR, v); check("R7 gisr", v, W'(m));
                check("R7 irq", W'(irq_o), W'(en == 1 && m != 0));
            end
        end

        // R8 control write rule
        wr(A_CTL, 32'hFFFF_FFFE);
        rd(A_CTL, v); check("R8 ctl store", v, 32'h8000_0002);
        wr(A_CTL, 32'h0);
        rd(A_CTL, v); check("R8 ctl clear", v, 32'h8000_0000);

        // R9 command register fields
        list_running[0] = 1'b1;
        wr(pa(0, O_CMD), 32'hFFFF_FFFF);
        rd(pa(0, O_CMD), v); check("R9 cmd list run", v, 32'h0FFF_80FF);
        list_running[0] = 1'b0; rx_running[0] = 1'b1;
        rd(pa(0, O_CMD), v); check("R9 cmd rx run", v, 32'h0FFF_40FF);
        rx_running[0] = 1'b0;

        // R10 engine requests
        wr(pa(2, O_CMD), 32'h1);
        check("R10 list start", W'(list_start_o), 32'h4);
        @(negedge clk); check("R10 list start ends", W'(list_start_o), 0);
        list_running[2] = 1'b1;
        wr(pa(2, O_CMD), 32'h1);
        check("R10 no start when running", W'(list_start_o), 0);
        wr(pa(2, O_CMD), 32'h0);
        check("R10 list stop", W'(list_stop_o), 32'h4);
        wr(pa(2, O_CMD), 32'h10);
        check("R10 rx start", W'(rx_start_o), 32'h4);
        rx_running[2] = 1'b1;
        wr(pa(2, O_CMD), 32'h0);
        check("R10 rx stop", W'(rx_stop_o), 32'h4);
        @(negedge clk); check("R10 rx stop ends", W'(rx_stop_o), 0);
        list_running = '0; rx_running = '0;

        // R11 error, active and issue rules
        @(negedge clk); err_event[3*W +: W] = 32'hF; @(negedge clk); err_event = '0;
        rd(pa(3, O_SERR), v); check("R11 serr set", v, 32'hF);
        wr(pa(3, O_SERR), 32'h5);
        rd(pa(3, O_SERR), v); check("R11 serr w1c", v, 32'hA);
        wr(pa(3, O_SACT), 32'h5);
        wr(pa(3, O_SACT), 32'h2);
        wr(pa(3, O_SACT), 32'h0);
        rd(pa(3, O_SACT), v); check("R11 sact w1s", v, 32'h7);
        wr(pa(3, O_ISSUE), 32'h30);
        wr(pa(3, O_ISSUE), 32'h0);
        rd(pa(3, O_ISSUE), v); check("R11 issue w1s", v, 32'h30);
        @(negedge clk); slot_retire[3*W +: W] = 32'h11; @(negedge clk); slot_retire = '0;
        rd(pa(3, O_SACT), v);  check("R11 sact retire", v, 32'h6);
        rd(pa(3, O_ISSUE), v); check("R11 issue retire", v, 32'h20);

        // R12 port reset on control field 1 -> 0
        wr(pa(3, O_SCTL), 32'h1);
        check("R12 no pulse on set", W'(port_reset_o), 0);
        wr(pa(3, O_SCTL), 32'h300);
        check("R12 reset pulse", W'(port_reset_o), 32'h8);
        @(negedge clk); check("R12 pulse ends", W'(port_reset_o), 0);
        rd(pa(3, O_SERR), v); check("R12 serr cleared", v, 0);
        rd(pa(3, O_SACT), v); check("R12 sact cleared", v, 0);
        rd(pa(3, O_ISSUE), v); check("R12 issue kept", v, 32'h20);
        rd(pa(3, O_SCTL), v); check("R12 sctl stored", v, 32'h300);
        rd(pa(3, O_TFD), v);  check("R12 tfd", v, 32'h7F);
        rd(pa(3, O_SIG), v);  check("R12 sig", v, 32'hFFFF_FFFF);
        wr(pa(3, O_SCTL), 32'h3);
        wr(pa(3, O_SCTL), 32'h0);
        check("R12 no pulse from 3", W'(port_reset_o), 0);

        // R13 link status
        dev_present = 4'b1010;
        for (int p = 0; p < NP; p++) begin
            rd(pa(p, O_SSTS), v); check("R13 sstat", v, dev_present[p] ? 32'h113 : 32'h0);
        end
        dev_present = 4'b0101;
        for (int p = 0; p < NP; p++) begin
            rd(pa(p, O_SSTS), v); check("R13 sstat swap", v, dev_present[p] ? 32'h113 : 32'h0);
        end

        // R14 index/data indirection
        wr(A_IDX, 32'hFFFF_FFFF);
        rd(A_IDX, v); check("R14 index mask", v, 32'h3FC);
        wr(A_IDX, W'(pa(1, O_IMSK)));
        wr(A_DATA, 32'h1234_5678);
        rd(pa(1, O_IMSK), v); check("R14 data write", v, 32'h1000_0078);
        rd(A_DATA, v);        check("R14 data read", v, 32'h1000_0078);
        wr(A_IDX, W'(A_CTL));
        rd(A_DATA, v);        check("R14 data to global", v, 32'h8000_0000);

        // R8 controller reset
        wr(pa(2, O_ISSUE), 32'h1);
        wr(A_CTL, 32'h3);
        check("R8 reset pulse", W'(hba_reset_o), 1);
        @(negedge clk); check("R8 reset pulse ends", W'(hba_reset_o), 0);
        rd(pa(1, O_IMSK), v);  check("R8 imask reset", v, 0);
        rd(pa(2, O_ISSUE), v); check("R8 issue reset", v, 0);
        rd(A_CTL, v);          check("R8 ctl reset", v, 32'h8000_0000);
        rd(A_IDX, v);          check("R8 index reset", v, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule